// File: doc/BRIEF.md
# Bit-Operation and Branch Execution Unit

This unit executes the single-bit, nibble and short arithmetic operations of an 8-bit processor on a byte from either the accumulator or memory. It can force a chosen bit to 1 or 0, branch on the state of a chosen bit, branch unconditionally, swap the two nibbles of a memory byte, write back the ones' complement of a memory byte, test a memory byte for zero, store an immediate into memory, and increment or decrement the accumulator or a memory byte. The fetch logic supplies the operation code, a bit index, both candidate operands, an immediate, the address of the next instruction and a signed 8-bit displacement. The unit returns the result byte with separate accumulator and memory write strobes, the N and Z flags and the program counter to continue from.

Control is a three-state machine. In `ST_IDLE` the unit waits. On the *accept* transition (ST_IDLE to ST_EXEC, taken when `op_valid` is high) every input is captured. The *compute* transition (ST_EXEC to ST_RETIRE, unconditional) registers the outcome. In `ST_RETIRE` `done` is high for one cycle and the strobes are valid. The *release* transition (ST_RETIRE to ST_IDLE, unconditional) ends the operation. While idle without a request, the *hold* transition keeps the unit in ST_IDLE. Requests that arrive while `busy` is high are dropped.

Top module: `bmu_core`

## Requirements
- R1: While reset is held, and at its release, `done`, `busy`, `acc_we` and `mem_we` are 0.
- R2: A request with `op_valid` high in an idle cycle is accepted at that clock edge. `busy` is then high for two cycles and `done` is high only in the second of them. Requests that arrive while busy have no effect.
- R3: Code 0 (set bit) yields the operand with bit `bit_sel` forced to 1. The operand is `mem_in` when `use_mem`=1 and `acc_in` otherwise. The result goes to that same place through `mem_we` or `acc_we`. Flags pass through unchanged.
- R4: Code 1 (clear bit) behaves like R3, except that bit `bit_sel` is forced to 0.
- R5: Code 2 branches when the selected bit of the operand is 0, and code 3 branches when it is 1. A taken branch gives `next_pc` = `pc_next` + sign-extended `br_off`, modulo 2^16. A branch not taken gives `pc_next`. Neither writes, and flags pass through.
- R6: Code 4 always branches to `pc_next` + sign-extended `br_off`, modulo 2^16, for offsets from -128 to +127. It does not write.
- R7: Code 5 writes `mem_in` rotated right by four, with its nibbles swapped, through `mem_we`. Flags pass through.
- R8: Code 6 writes `~mem_in` through `mem_we`. N is set to bit 7 of the written value, and Z to whether that value is zero.
- R9: Code 7 sets N to bit 7 of `mem_in` and Z to whether `mem_in` is zero. It does not write.
- R10: Code 8 writes `imm_in` through `mem_we`. Flags pass through.
- R11: Code 9 (increment) and code 10 (decrement) act on the operand selected by `use_mem` and wrap modulo 256. They write back to the same place and update N and Z from the result.
- R12: Codes 11 to 15 have no combined test-and-modify meaning. They write nothing, pass the flags through and give `next_pc` = `pc_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation code |
| bit_sel | input | 3 | Bit index, 0 to 7 |
| use_mem | input | 1 | Select the memory byte (1) or the accumulator (0) for bit and step operations |
| acc_in | input | 8 | Accumulator value |
| mem_in | input | 8 | Memory byte value |
| imm_in | input | 8 | Immediate for store |
| pc_next | input | 16 | Address of next instruction |
| br_off | input | 8 | Signed branch displacement |
| n_in | input | 1 | Current N flag |
| z_in | input | 1 | Current Z flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Results valid this cycle |
| result | output | 8 | Result byte |
| acc_we | output | 1 | Write result to accumulator |
| mem_we | output | 1 | Write result to memory |
| n_out | output | 1 | Updated N flag |
| z_out | output | 1 | Updated Z flag |
| next_pc | output | 16 | Program counter to continue from |

## Verification
A state machine stuck in one state, or one that skips a state, shows at the ports within one or two cycles of the next request. `done` or `busy` then leaves the fixed two-cycle pattern, and the bench compares that pattern against its own model on every cycle. A wrongly captured operand, bit index or opcode shows in the retire cycle of that same operation, as a wrong byte, a strobe on the wrong target, a moved flag or a wrong `next_pc`. A request wrongly accepted while busy shows as an extra `done` pulse or as results that belong to the wrong request.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_SETB  = 4'd0;
    localparam logic [OP_W-1:0] OP_CLRB  = 4'd1;
    localparam logic [OP_W-1:0] OP_BRCLR = 4'd2;
    localparam logic [OP_W-1:0] OP_BRSET = 4'd3;
    localparam logic [OP_W-1:0] OP_BRA   = 4'd4;
    localparam logic [OP_W-1:0] OP_ROR4  = 4'd5;
    localparam logic [OP_W-1:0] OP_CPL   = 4'd6;
    localparam logic [OP_W-1:0] OP_TSTZ  = 4'd7;
    localparam logic [OP_W-1:0] OP_LDIM  = 4'd8;
    localparam logic [OP_W-1:0] OP_INC   = 4'd9;
    localparam logic [OP_W-1:0] OP_DEC   = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_RETIRE = 2'd2
    } bmu_state_e;
endpackage

// File: rtl/bmu_bitops.sv
module bmu_bitops #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] set_v,
    output logic [DATA_W-1:0] clr_v,
    output logic              bit_v
);
    // One mask bit per lane, decoded from the index.
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        logic hit;
        assign hit      = (idx == IDX_W'(g));
        assign set_v[g] = opnd[g] | hit;
        assign clr_v[g] = opnd[g] & ~hit;
    end

    assign bit_v = opnd[idx];
endmodule

// File: rtl/bmu_alu.sv
module bmu_alu #(
    parameter int DATA_W = 8,
    localparam int HALF = DATA_W / 2
) (
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] rot_v,
    output logic [DATA_W-1:0] cpl_v,
    output logic [DATA_W-1:0] inc_v,
    output logic [DATA_W-1:0] dec_v
);
    assign rot_v = {opnd[HALF-1:0], opnd[DATA_W-1:HALF]};
    assign cpl_v = ~opnd;
    assign inc_v = opnd + DATA_W'(1);
    assign dec_v = opnd - DATA_W'(1);
endmodule

// File: rtl/bmu_branch.sv
module bmu_branch #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [OFF_W-1:0]  off,
    input  logic              take,
    output logic [ADDR_W-1:0] target
);
    logic [ADDR_W-1:0] off_ext;

    if (ADDR_W > OFF_W) begin : g_extend
        assign off_ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
    end else begin : g_trunc
        assign off_ext = off[ADDR_W-1:0];
    end

    assign target = take ? (pc_next + off_ext) : pc_next;
endmodule

// File: rtl/bmu_core.sv
module bmu_core
    import bmu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic              use_mem,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mem_in,
    input  logic [DATA_W-1:0] imm_in,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [OFF_W-1:0]  br_off,
    input  logic              n_in,
    input  logic              z_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              acc_we,
    output logic              mem_we,
    output logic              n_out,
    output logic              z_out,
    output logic [ADDR_W-1:0] next_pc
);
    bmu_state_e state_q, state_d;

    // Captured request
    logic [OP_W-1:0]   op_q;
    logic [IDX_W-1:0]  idx_q;
    logic              sel_q;
    logic [DATA_W-1:0] acc_q, mem_q, imm_q;
    logic [ADDR_W-1:0] pc_q;
    logic [OFF_W-1:0]  off_q;
    logic              n_q, z_q;

    // Registered outcome
    logic [DATA_W-1:0] res_q;
    logic              awe_q, mwe_q, nout_q, zout_q;
    logic [ADDR_W-1:0] npc_q;

    // Execution datapath
    logic [DATA_W-1:0] opnd_c, set_c, clr_c, rot_c, cpl_c, inc_c, dec_c;
    logic [DATA_W-1:0] res_c, flag_src;
    logic              bit_c, take_c, awe_c, mwe_c, fupd_c;
    logic [ADDR_W-1:0] npc_c;

    assign opnd_c = sel_q ? mem_q : acc_q;

    bmu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .opnd (opnd_c),
        .idx  (idx_q),
        .set_v(set_c),
        .clr_v(clr_c),
        .bit_v(bit_c)
    );

    bmu_alu #(.DATA_W(DATA_W)) u_alu_mem (
        .opnd (mem_q),
        .rot_v(rot_c),
        .cpl_v(cpl_c),
        .inc_v(),
        .dec_v()
    );

    bmu_alu #(.DATA_W(DATA_W)) u_alu_sel (
        .opnd (opnd_c),
        .rot_v(),
        .cpl_v(),
        .inc_v(inc_c),
        .dec_v(dec_c)
    );

    bmu_branch #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_branch (
        .pc_next(pc_q),
        .off    (off_q),
        .take   (take_c),
        .target (npc_c)
    );

    always_comb begin
        res_c    = opnd_c;
        awe_c    = 1'b0;
        mwe_c    = 1'b0;
        take_c   = 1'b0;
        fupd_c   = 1'b0;
        flag_src = opnd_c;
        case (op_q)
            OP_SETB: begin
                res_c = set_c;
                awe_c = ~sel_q;
                mwe_c = sel_q;
            end
            OP_CLRB: begin
                res_c = clr_c;
                awe_c = ~sel_q;
                mwe_c = sel_q;
            end
            OP_BRCLR: take_c = ~bit_c;
            OP_BRSET: take_c = bit_c;
            OP_BRA:   take_c = 1'b1;
            OP_ROR4: begin
                res_c = rot_c;
                mwe_c = 1'b1;
            end
            OP_CPL: begin
                res_c    = cpl_c;
                mwe_c    = 1'b1;
                fupd_c   = 1'b1;
                flag_src = cpl_c;
            end
            OP_TSTZ: begin
                res_c    = mem_q;
                fupd_c   = 1'b1;
                flag_src = mem_q;
            end
            OP_LDIM: begin
                res_c = imm_q;
                mwe_c = 1'b1;
            end
            OP_INC: begin
                res_c    = inc_c;
                awe_c    = ~sel_q;
                mwe_c    = sel_q;
                fupd_c   = 1'b1;
                flag_src = inc_c;
            end
            OP_DEC: begin
                res_c    = dec_c;
                awe_c    = ~sel_q;
                mwe_c    = sel_q;
                fupd_c   = 1'b1;
                flag_src = dec_c;
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = op_valid ? ST_EXEC : ST_IDLE;
            ST_EXEC:   state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request capture on the accept transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            idx_q <= '0;
            sel_q <= 1'b0;
            acc_q <= '0;
            mem_q <= '0;
            imm_q <= '0;
            pc_q  <= '0;
            off_q <= '0;
            n_q   <= 1'b0;
            z_q   <= 1'b0;
        end else if (state_q == ST_IDLE && op_valid) begin
            op_q  <= op_code;
            idx_q <= bit_sel;
            sel_q <= use_mem;
            acc_q <= acc_in;
            mem_q <= mem_in;
            imm_q <= imm_in;
            pc_q  <= pc_next;
            off_q <= br_off;
            n_q   <= n_in;
            z_q   <= z_in;
        end
    end

    // Output registers, loaded on the compute transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            awe_q  <= 1'b0;
            mwe_q  <= 1'b0;
            nout_q <= 1'b0;
            zout_q <= 1'b0;
            npc_q  <= '0;
        end else if (state_q == ST_EXEC) begin
            res_q  <= res_c;
            awe_q  <= awe_c;
            mwe_q  <= mwe_c;
            nout_q <= fupd_c ? flag_src[DATA_W-1] : n_q;
            zout_q <= fupd_c ? (flag_src == '0) : z_q;
            npc_q  <= npc_c;
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_RETIRE);
    assign result  = res_q;
    assign acc_we  = done & awe_q;
    assign mem_we  = done & mwe_q;
    assign n_out   = nout_q;
    assign z_out   = zout_q;
    assign next_pc = npc_q;

    // R2: compute always leads to a single-cycle done pulse
    assert_exec_to_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |=> done);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_write_only_in_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we || mem_we) |-> done);
    // R5 / R6: branch codes never write
    assert_branch_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_BRCLR || op_q == OP_BRSET || op_q == OP_BRA))
        |-> (!acc_we && !mem_we));
    // R7: nibble swap relates captured byte to output
    assert_ror_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_ROR4)
        |-> (result == {mem_q[3:0], mem_q[DATA_W-1:4]} && n_out == n_q && z_out == z_q));
    // R9: test performs no write
    assert_test_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_TSTZ) |-> (!acc_we && !mem_we));
    // R12: unused codes fall through
    assert_unused_fallthrough_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q > OP_DEC)
        |-> (!acc_we && !mem_we && next_pc == pc_q && n_out == n_q && z_out == z_q));
endmodule

// File: tb/tb_bmu_core.sv
module tb_bmu_core;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, op_valid, use_mem, n_in, z_in;
    logic [3:0]  op_code;
    logic [2:0]  bit_sel;
    logic [7:0]  acc_in, mem_in, imm_in, br_off;
    logic [15:0] pc_next;
    logic        busy, done, acc_we, mem_we, n_out, z_out;
    logic [7:0]  result;
    logic [15:0] next_pc;

    bmu_core dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .bit_sel(bit_sel), .use_mem(use_mem), .acc_in(acc_in), .mem_in(mem_in),
        .imm_in(imm_in), .pc_next(pc_next), .br_off(br_off), .n_in(n_in),
        .z_in(z_in), .busy(busy), .done(done), .result(result),
        .acc_we(acc_we), .mem_we(mem_we), .n_out(n_out), .z_out(z_out),
        .next_pc(next_pc)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2, 3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R9";
            8: return "R10";
            9, 10: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [7:0] pick_byte();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h7F;
            3: return 8'h80;
            default: return 8'($urandom);
        endcase
    endfunction

    // Reference model state
    int          ms;
    int          e_op;
    logic [7:0]  e_res;
    bit          e_aw, e_mw, e_n, e_z;
    logic [15:0] e_pc;

    initial begin
        logic [7:0] opnd;
        bit         take;
        string      t;
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; bit_sel = '0; use_mem = 1'b0;
        acc_in = '0; mem_in = '0; imm_in = '0; pc_next = '0; br_off = '0;
        n_in = 1'b0; z_in = 1'b0;
        ms = 0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(acc_we == 1'b0 && mem_we == 1'b0, "R1", "strobes in reset", {acc_we, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1", "idle after release", {done, busy}, 0);

        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            chk(done == (ms == 2), "R2", "done", done, (ms == 2));
            chk(busy == (ms != 0), "R2", "busy", busy, (ms != 0));
            if (ms == 2) begin
                t = tag_of(e_op);
                chk(acc_we == e_aw, t, "acc_we", acc_we, e_aw);
                chk(mem_we == e_mw, t, "mem_we", mem_we, e_mw);
                chk(n_out == e_n, t, "n_out", n_out, e_n);
                chk(z_out == e_z, t, "z_out", z_out, e_z);
                chk(next_pc == e_pc, t, "next_pc", next_pc, e_pc);
                if (e_aw || e_mw) chk(result == e_res, t, "result", result, e_res);
            end

            // Drive a new request (also while busy, where it must be ignored: R2)
            op_valid = ($urandom % 3) != 0;
            op_code  = 4'($urandom);
            bit_sel  = 3'($urandom);
            use_mem  = 1'($urandom);
            acc_in   = pick_byte();
            mem_in   = pick_byte();
            imm_in   = pick_byte();
            br_off   = pick_byte();
            case ($urandom % 4)
                0: pc_next = 16'hFFFF;
                1: pc_next = 16'h0000;
                2: pc_next = 16'h0005;
                default: pc_next = 16'($urandom);
            endcase
            n_in = 1'($urandom);
            z_in = 1'($urandom);

            // Model advances to the next rising edge
            if (ms == 0 && op_valid) begin
                e_op = int'(op_code);
                opnd = use_mem ? mem_in : acc_in;
                e_res = opnd; e_aw = 0; e_mw = 0; e_n = n_in; e_z = z_in; take = 0;
                case (e_op)
                    0:  begin e_res = opnd | (8'h01 << bit_sel);  e_aw = !use_mem; e_mw = use_mem; end
                    1:  begin e_res = opnd & ~(8'h01 << bit_sel); e_aw = !use_mem; e_mw = use_mem; end
                    2:  take = (opnd[bit_sel] == 1'b0);
                    3:  take = (opnd[bit_sel] == 1'b1);
                    4:  take = 1;
                    5:  begin e_res = {mem_in[3:0], mem_in[7:4]}; e_mw = 1; end
                    6:  begin e_res = ~mem_in; e_mw = 1; e_n = e_res[7]; e_z = (e_res == 0); end
                    7:  begin e_n = mem_in[7]; e_z = (mem_in == 0); end
                    8:  begin e_res = imm_in; e_mw = 1; end
                    9:  begin e_res = 8'((int'(opnd) + 1) % 256); e_aw = !use_mem; e_mw = use_mem;
                              e_n = e_res[7]; e_z = (e_res == 0); end
                    10: begin e_res = 8'((int'(opnd) + 255) % 256); e_aw = !use_mem; e_mw = use_mem;
                              e_n = e_res[7]; e_z = (e_res == 0); end
                    default: ;
                endcase
                e_pc = take ? 16'((int'(pc_next) + int'($signed(br_off)) + 65536) % 65536) : pc_next;
                ms = 1;
            end else if (ms == 1) begin
                ms = 2;
            end else if (ms == 2) begin
                ms = 0;
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule